// File: doc/BRIEF.md
# Register Type-Tag Tracker and Functional-Unit Steering

This front-end block keeps one type bit for every architectural register. A set bit means the register holds a floating-point value. A clear bit means it holds integer or address data. The bits live in the block, apart from the register file. They are updated from decoded instructions only, so no computation result is ever waited on and the bits never need renaming.

Each decoded instruction arrives as a 3-bit kind code, a source index and a destination index. The block uses them to update the destination tag. For shared opcodes it also picks the FP or integer functional unit by reading the source register's tag. On a procedure entry it hands out the current tag word for saving, with no wait. On a procedure exit it holds decode stalled until the load/store unit returns the saved tag word, and then it installs that word.

Top module: `regtag_steer`

## Requirements
- R1: After reset all tags are 0 (integer), `dec_stall`, `steer_valid`, `illegal_op` and `save_valid` are 0, and `save_word` is 0.
- R2: Kind codes are 0 no-op, 1 integer load, 2 FP load, 3 FP-only op, 4 integer-only op, 5 shared op, 6 procedure entry, 7 procedure exit. An accepted FP load (kind 2) sets the destination tag.
- R3: An accepted integer load (kind 1) clears the destination tag.
- R4: One cycle after a shared op (kind 5) is accepted, `steer_valid` is 1 and `steer_fp` equals the tag of `dec_src`.
- R5: One cycle after an FP-only op (kind 3) is accepted, `steer_valid` is 1 and `steer_fp` is 1. If the source tag was clear, `illegal_op` is 1 and no tag changes. Otherwise the destination tag is set.
- R6: One cycle after an integer-only op (kind 4) is accepted, `steer_valid` is 1 and `steer_fp` is 0. If the source tag was set, `illegal_op` is 1 and no tag changes. Otherwise the destination tag is cleared.
- R7: A shared op copies the source tag into the destination tag. When source and destination are the same register, the steering uses the tag value from before the update.
- R8: The tag of register 0 is always 0, whatever writes or restore words target it.
- R9: One cycle after a procedure entry (kind 6) is accepted, `save_valid` pulses for one cycle and `save_word` bit i equals tag i. `dec_stall` stays 0.
- R10: `dec_stall` rises the cycle after a procedure exit (kind 7) is accepted. An instruction presented while `dec_stall` is 1 is not accepted: it changes no tag and produces no output pulse.
- R11: When `rs_valid` is 1 while `dec_stall` is 1, the tags take `rs_word` (bit 0 forced to 0) and `dec_stall` falls the next cycle. `rs_valid` while not stalled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_kind | input | 3 | Instruction kind code (see R2) |
| dec_src | input | 5 | First source register index |
| dec_dst | input | 5 | Destination register index |
| dec_stall | output | 1 | Decode held while waiting for restore word |
| rs_valid | input | 1 | Restore word from load/store unit valid |
| rs_word | input | 32 | Restore tag word |
| steer_valid | output | 1 | Steering decision valid |
| steer_fp | output | 1 | 1 = FP unit, 0 = integer unit |
| illegal_op | output | 1 | Operand type mismatch for a typed op |
| save_valid | output | 1 | Tag snapshot valid for saving |
| save_word | output | 32 | Tag snapshot, bit i = register i |

## Verification
The hardest case to reach from the ports is a restore word that arrives in the same cycle as a presented instruction while decode is still stalled, followed at once by an instruction that reads a restored tag. The stimulus restricts register indices to a small set so that tags, self-overwrites and register 0 collide often. It also issues exits at random and delivers the restore word after a random delay, sometimes while decode is free, where the word must be ignored. A cycle-by-cycle model in the bench follows every tag and the stall state and compares all outputs on every clock.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
    typedef enum logic [2:0] {
        K_NOP = 3'd0,
        K_LDI = 3'd1,
        K_LDF = 3'd2,
        K_FPO = 3'd3,
        K_INO = 3'd4,
        K_SHR = 3'd5,
        K_ENT = 3'd6,
        K_EXT = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic steer;
        logic to_fp;
        logic bad;
        logic wr;
        logic wr_val;
    } steer_t;
endpackage

// File: rtl/regtag_classify.sv
module regtag_classify
    import regtag_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       src_tag,
    output steer_t     res
);
    always_comb begin
        res = '0;
        case (op_kind_e'(kind))
            K_LDI: begin res.wr = 1'b1; res.wr_val = 1'b0; end
            K_LDF: begin res.wr = 1'b1; res.wr_val = 1'b1; end
            K_FPO: begin
                res.steer  = 1'b1;
                res.to_fp  = 1'b1;
                res.bad    = ~src_tag;
                res.wr     = src_tag;
                res.wr_val = 1'b1;
            end
            K_INO: begin
                res.steer  = 1'b1;
                res.to_fp  = 1'b0;
                res.bad    = src_tag;
                res.wr     = ~src_tag;
                res.wr_val = 1'b0;
            end
            K_SHR: begin
                res.steer  = 1'b1;
                res.to_fp  = src_tag;
                res.wr     = 1'b1;
                res.wr_val = src_tag;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/regtag_store.sv
module regtag_store #(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic            wr_val,
    input  logic            ld_en,
    input  logic [NREG-1:0] ld_word,
    output logic [NREG-1:0] tags
);
    logic [NREG-1:0] tags_d, tags_q;

    always_comb begin
        tags_d = tags_q;
        if (ld_en)
            tags_d = ld_word;
        else if (wr_en)
            tags_d[wr_idx] = wr_val;
        tags_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tags_q <= '0;
        else        tags_q <= tags_d;
    end

    assign tags = tags_q;

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> tags_q[NREG-1:1] == $past(ld_word[NREG-1:1]));
endmodule

// File: rtl/regtag_steer.sv
module regtag_steer
    import regtag_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [2:0]      dec_kind,
    input  logic [AW-1:0]   dec_src,
    input  logic [AW-1:0]   dec_dst,
    output logic            dec_stall,
    input  logic            rs_valid,
    input  logic [NREG-1:0] rs_word,
    output logic            steer_valid,
    output logic            steer_fp,
    output logic            illegal_op,
    output logic            save_valid,
    output logic [NREG-1:0] save_word
);
    typedef struct packed {
        logic            waiting;
        logic            stv;
        logic            fp;
        logic            bad;
        logic            sv;
        logic [NREG-1:0] sw;
    } st_t;

    st_t st_d, st_q;
    logic [NREG-1:0] tags;
    steer_t cls;
    logic acc, restore;

    assign acc     = dec_valid & ~st_q.waiting;
    assign restore = rs_valid & st_q.waiting;

    regtag_classify u_cls (
        .kind    (dec_kind),
        .src_tag (tags[dec_src]),
        .res     (cls)
    );

    regtag_store #(.NREG(NREG)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc & cls.wr),
        .wr_idx  (dec_dst),
        .wr_val  (cls.wr_val),
        .ld_en   (restore),
        .ld_word (rs_word),
        .tags    (tags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stv = acc & cls.steer;
        st_d.fp  = acc & cls.to_fp;
        st_d.bad = acc & cls.bad;
        st_d.sv  = acc & (op_kind_e'(dec_kind) == K_ENT);
        if (acc && op_kind_e'(dec_kind) == K_ENT)
            st_d.sw = tags;
        if (restore)
            st_d.waiting = 1'b0;
        else if (acc && op_kind_e'(dec_kind) == K_EXT)
            st_d.waiting = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_stall   = st_q.waiting;
    assign steer_valid = st_q.stv;
    assign steer_fp    = st_q.fp;
    assign illegal_op  = st_q.bad;
    assign save_valid  = st_q.sv;
    assign save_word   = st_q.sw;

    // R10
    exit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_stall && dec_kind == 3'd7) |=> dec_stall);
    // R10
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |=> !steer_valid && !save_valid && !illegal_op);
    // R11
    restore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && rs_valid) |=> !dec_stall);
    // R8
    save_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid |-> !save_word[0]);
    // R6
    int_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_stall && dec_kind == 3'd4) |=> steer_valid && !steer_fp);
    // R5
    fp_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_stall && dec_kind == 3'd3) |=> steer_valid && steer_fp);
    // R5
    illegal_implies_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> steer_valid);
endmodule

// File: tb/regtag_steer_tb.sv
module regtag_steer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [2:0]  dec_kind = '0;
    logic [4:0]  dec_src = '0, dec_dst = '0;
    logic        dec_stall;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_word = '0;
    logic        steer_valid, steer_fp, illegal_op, save_valid;
    logic [31:0] save_word;

    int total = 0, bad = 0;

    bit [31:0] m_tag;
    bit        m_wait, e_stv, e_fp, e_bad, e_sv;
    bit [31:0] e_sw;

    always #10 clk = ~clk;

    regtag_steer u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_src(dec_src), .dec_dst(dec_dst), .dec_stall(dec_stall),
        .rs_valid(rs_valid), .rs_word(rs_word), .steer_valid(steer_valid),
        .steer_fp(steer_fp), .illegal_op(illegal_op), .save_valid(save_valid),
        .save_word(save_word)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R10 dec_stall", dec_stall, m_wait);
        chk("R4 steer_valid", steer_valid, e_stv);
        chk("R4 steer_fp", steer_fp, e_fp);
        chk("R5 illegal_op", illegal_op, e_bad);
        chk("R9 save_valid", save_valid, e_sv);
        chk("R9 save_word", save_word, e_sw);
    endtask

    // model step for the inputs now on the pins (applied at the next edge)
    task automatic model_step();
        bit acc, st;
        acc = dec_valid && !m_wait;
        st  = m_tag[dec_src];
        e_stv = 0; e_fp = 0; e_bad = 0; e_sv = 0;
        if (rs_valid && m_wait) begin
            m_tag  = rs_word;           // R11
            m_wait = 0;
        end else if (acc) begin
            case (dec_kind)
                3'd1: m_tag[dec_dst] = 0;                    // R3
                3'd2: m_tag[dec_dst] = 1;                    // R2
                3'd3: begin e_stv = 1; e_fp = 1; e_bad = !st;
                            if (st) m_tag[dec_dst] = 1; end  // R5
                3'd4: begin e_stv = 1; e_fp = 0; e_bad = st;
                            if (!st) m_tag[dec_dst] = 0; end // R6
                3'd5: begin e_stv = 1; e_fp = st; m_tag[dec_dst] = st; end // R7
                3'd6: begin e_sv = 1; e_sw = m_tag; end      // R9
                3'd7: m_wait = 1;                            // R10
                default: ;
            endcase
        end
        if (acc) begin
            if (dec_kind == 3'd3) begin e_stv = 1; e_fp = 1; end
        end
        m_tag[0] = 0;                                        // R8
    endtask

    task automatic drive(bit v, bit [2:0] k, bit [4:0] s, bit [4:0] d, bit rv, bit [31:0] w);
        dec_valid = v; dec_kind = k; dec_src = s; dec_dst = d;
        rs_valid = rv; rs_word = w;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [4:0] pool [6];
        int wait_cnt;
        pool = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd17, 5'd31};
        m_tag = 0; m_wait = 0; e_stv = 0; e_fp = 0; e_bad = 0; e_sv = 0; e_sw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 stall", dec_stall, 0);
        chk("R1 steer_valid", steer_valid, 0);
        chk("R1 illegal", illegal_op, 0);
        chk("R1 save_word", save_word, 0);
        drive(1, 3'd6, 0, 0, 0, 0);                // R1 snapshot all zero
        drive(1, 3'd3, 5, 5, 0, 0);                // R5 illegal, no change
        drive(1, 3'd2, 0, 5, 0, 0);                // R2 FP load sets r5
        drive(1, 3'd2, 0, 0, 0, 0);                // R8 r0 stays clear
        drive(1, 3'd5, 5, 6, 0, 0);                // R4 shared to FP, R7 copy
        drive(1, 3'd4, 6, 7, 0, 0);                // R6 illegal
        drive(1, 3'd1, 0, 5, 0, 0);                // R3 int load clears r5
        drive(1, 3'd5, 6, 6, 0, 0);                // R7 self overwrite
        drive(1, 3'd6, 0, 0, 0, 0);                // R9 snapshot
        drive(0, 0, 0, 0, 1, 32'hFFFF_FFFF);       // R11 ignored when not stalled
        drive(1, 3'd6, 0, 0, 0, 0);                // R11 check via snapshot
        drive(1, 3'd7, 0, 0, 0, 0);                // R10 exit
        drive(1, 3'd2, 0, 9, 0, 0);                // R10 ignored while stalled
        drive(1, 3'd6, 0, 0, 0, 0);                // R10 ignored while stalled
        drive(1, 3'd5, 9, 9, 1, 32'hA5A5_0203);    // R11 restore in same cycle
        drive(1, 3'd5, 9, 9, 0, 0);                // R7 reads restored tag
        drive(1, 3'd6, 0, 0, 0, 0);                // R11 snapshot
        wait_cnt = 0;
        for (int i = 0; i < 3000; i++) begin
            bit [2:0] k;
            k = 3'($urandom_range(0, 7));
            if (k == 3'd7 && ($urandom_range(0, 3) != 0)) k = 3'd5;
            drive(($urandom_range(0, 5) != 0), k,
                  pool[$urandom_range(0, 5)], pool[$urandom_range(0, 5)],
                  ($urandom_range(0, 4) == 0), $urandom());
        end
        drive(0, 0, 0, 0, 1, 32'h1);
        drive(1, 3'd6, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule